// File: doc/BRIEF.md
# Cascaded Second-Order IIR Filter

This block is a streaming recursive filter made of a chain of second-order sections (three by default). Every section keeps a single pair of state registers, and that pair serves both its recursive (pole) path and its feedforward (zero) path. Each section first forms a new state value from its input plus two weighted past states. It then forms its output as a weighted sum of the new state and the same two past states. The output of one section is the input of the next, so the whole filter holds only two state words per section.

A sample is accepted on every clock where `in_valid` is high, and each accepted sample produces exactly one filtered sample. Samples are 16-bit two's complement integers. Coefficients are signed fixed-point numbers with 14 fraction bits, so the code 16384 stands for 1.0 and the usable range is just under ±2. Every sum of products is kept at full width, rounded, and clamped to 16 bits before it is stored as state or passed downstream.

Coefficients come from the static `coef_in` bus. With the parameter `USE_PORT_COEF` cleared, they come from the `COEF_INIT` parameter instead, whose default makes every section a unity pass-through.

Top module: `sos_iir_chain`

## Requirements
- R1: Each section forms its state as s(n) = x(n) + a1·s(n−1) + a2·s(n−2). The recursive terms are added, never subtracted, so a1 = +0.5 turns an impulse of 8000 into 8000, 4000, 2000, 1000, and a1 = −0.5 gives alternating signs.
- R2: Each section outputs y(n) = b0·s(n) + b1·s(n−1) + b2·s(n−2), using the same two state registers. With only b1 = 1.0 in every section, an input appears at the output three accepted samples later.
- R3: The sections are chained: section k+1 takes the rounded and clamped output of section k as its input, and the top output is the output of the last section. With unity sections, the output equals the input.
- R4: Coefficients are signed 16-bit with 14 fraction bits (16384 = 1.0). On `coef_in`, section k uses bits [(5k+j)·16 +: 16], where j = 0 is b0, 1 is b1, 2 is b2, 3 is a1 and 4 is a2. Each section uses only its own five fields.
- R5: Each full-width sum is rounded to the nearest integer, with halves rounded upward: (sum + 8192) >> 14, an arithmetic shift. With b0 = 0.5, input 3 gives 2 and input −3 gives −1.
- R6: Every rounded result is clamped to [−32768, 32767] before it is stored as state or output. A clamped state value is what later samples see.
- R7: State and output registers change only on clocks where `in_valid` is high. While `in_valid` is low, `in_data` has no effect on any later output.
- R8: `out_valid` is high for exactly one clock per accepted sample, three clocks after the accepting edge (one clock per section), and `out_data` holds its value until the next result.
- R9: A synchronous reset clears every state register, `out_data` and `out_valid` to zero. After reset the filter responds as a freshly started one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe; high means `in_data` is accepted this clock |
| in_data | input | 16 | Input sample, signed two's complement |
| coef_in | input | 240 | Static coefficients, five 16-bit fields per section |
| out_valid | output | 1 | One-clock pulse per filtered sample |
| out_data | output | 16 | Filtered sample, signed two's complement |

## Verification
The bench goes after exact half-way rounding in both signs: a design that truncates, or rounds halves away from zero, returns 1 or −2 where 2 and −1 are due. It drives the feedback coefficients with both signs, which catches a design that subtracts the recursive terms. It also overflows the state register and then checks that the clamped value, not a wrapped one, comes back on later samples. Streams with idle gaps and garbage data on the idle cycles expose a design that updates its state without the strobe. Single-sample pushes pin `out_valid` to exactly the third clock, so a missing or extra pipeline register shows up as a pulse in the wrong cycle.

// File: rtl/iir_sos_pkg.sv
package iir_sos_pkg;
   // Field slots inside one section's coefficient group; the bus layout depends on this order
   localparam int SLOT_B0   = 0;
   localparam int SLOT_B1   = 1;
   localparam int SLOT_B2   = 2;
   localparam int SLOT_A1   = 3;
   localparam int SLOT_A2   = 4;
   localparam int SLOTS_PER = 5;
   localparam int MAX_BANK  = 1024;

   // Builds a coefficient bank in which every section passes its input straight through
   function automatic logic [MAX_BANK-1:0] unity_bank(input int n_sect, input int cw, input int fw);
      logic [MAX_BANK-1:0] r;
      r = '0;
      for (int k = 0; k < n_sect; k++) begin
         r = r | ((MAX_BANK'(1) << fw) << (k * SLOTS_PER * cw + SLOT_B0 * cw));
      end
      return r;
   endfunction
endpackage

// File: rtl/round_sat.sv
module round_sat #(
   parameter int ACC_W  = 34,
   parameter int DATA_W = 16,
   parameter int FRAC_W = 14
) (
   input  logic signed [ACC_W-1:0]  acc,
   output logic signed [DATA_W-1:0] q
);
   localparam logic signed [ACC_W-1:0] HALF = ACC_W'(64'sd1 <<< (FRAC_W - 1));
   localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
   localparam logic signed [ACC_W-1:0] MINV = ACC_W'(-(64'sd1 <<< (DATA_W - 1)));

   generate
      if (FRAC_W < 1 || ACC_W <= DATA_W + FRAC_W) begin : g_bad_width
         $error("round_sat: accumulator too narrow or no fraction bits");
      end
   endgenerate

   logic signed [ACC_W-1:0] biased;
   logic signed [ACC_W-1:0] shifted;

   always_comb begin
      biased  = acc + HALF;
      shifted = biased >>> FRAC_W;
      if (shifted > MAXV) begin
         q = MAXV[DATA_W-1:0];
      end else if (shifted < MINV) begin
         q = MINV[DATA_W-1:0];
      end else begin
         q = shifted[DATA_W-1:0];
      end
   end
endmodule

// File: rtl/coef_bank.sv
module coef_bank #(
   parameter int                   BANK_W        = 240,
   parameter bit                   USE_PORT_COEF = 1'b1,
   parameter logic [BANK_W-1:0]    COEF_INIT     = '0
) (
   input  logic [BANK_W-1:0] coef_port,
   output logic [BANK_W-1:0] coef_out
);
   // Parameter picks the source; the unused leg folds away
   assign coef_out = USE_PORT_COEF ? coef_port : COEF_INIT;
endmodule

// File: rtl/sos_stage.sv
module sos_stage
   import iir_sos_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int COEF_W = 16,
   parameter int FRAC_W = 14
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          v_in,
   input  logic signed [DATA_W-1:0]      x_in,
   input  logic [SLOTS_PER*COEF_W-1:0]   coef,
   output logic                          v_out,
   output logic signed [DATA_W-1:0]      y_out
);
   localparam int ACC_W = DATA_W + COEF_W + 2;

   logic signed [COEF_W-1:0] c_b0, c_b1, c_b2, c_a1, c_a2;
   assign c_b0 = coef[SLOT_B0*COEF_W +: COEF_W];
   assign c_b1 = coef[SLOT_B1*COEF_W +: COEF_W];
   assign c_b2 = coef[SLOT_B2*COEF_W +: COEF_W];
   assign c_a1 = coef[SLOT_A1*COEF_W +: COEF_W];
   assign c_a2 = coef[SLOT_A2*COEF_W +: COEF_W];

   logic signed [DATA_W-1:0] st1_q, st2_q, y_q;
   logic                     v_q;
   logic signed [DATA_W-1:0] st_new, y_new;
   logic signed [ACC_W-1:0]  acc_fb, acc_ff;

   always_comb begin
      acc_fb = (ACC_W'(x_in) <<< FRAC_W)
             + ACC_W'(c_a1) * ACC_W'(st1_q)
             + ACC_W'(c_a2) * ACC_W'(st2_q);
      acc_ff = ACC_W'(c_b0) * ACC_W'(st_new)
             + ACC_W'(c_b1) * ACC_W'(st1_q)
             + ACC_W'(c_b2) * ACC_W'(st2_q);
   end

   round_sat #(.ACC_W(ACC_W), .DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_rs_state (
      .acc (acc_fb),
      .q   (st_new)
   );

   round_sat #(.ACC_W(ACC_W), .DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_rs_out (
      .acc (acc_ff),
      .q   (y_new)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st1_q <= '0;
         st2_q <= '0;
         y_q   <= '0;
         v_q   <= 1'b0;
      end else begin
         v_q <= v_in;
         if (v_in) begin
            st1_q <= st_new;
            st2_q <= st1_q;
            y_q   <= y_new;
         end
      end
   end

   assign v_out = v_q;
   assign y_out = y_q;

   // R2: the older state tap always takes the previous newer tap
   assert_state_shift_R2: assert property (@(posedge clk) disable iff (rst)
      v_in |=> (st2_q == $past(st1_q)));

   // R7: no strobe, no movement of state or output
   assert_state_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !v_in |=> ($stable(st1_q) && $stable(st2_q) && $stable(y_q)));

   // R8: one clock of latency through every section
   assert_valid_pipe_R8: assert property (@(posedge clk) disable iff (rst)
      v_in |=> v_out);

   assert_valid_idle_R8: assert property (@(posedge clk) disable iff (rst)
      !v_in |=> !v_out);
endmodule

// File: rtl/sos_iir_chain.sv
module sos_iir_chain
   import iir_sos_pkg::*;
#(
   parameter int   N_SECT        = 3,
   parameter int   DATA_W        = 16,
   parameter int   COEF_W        = 16,
   parameter int   FRAC_W        = 14,
   parameter bit   USE_PORT_COEF = 1'b1,
   parameter logic [N_SECT*SLOTS_PER*COEF_W-1:0] COEF_INIT =
      (N_SECT*SLOTS_PER*COEF_W)'(iir_sos_pkg::unity_bank(N_SECT, COEF_W, FRAC_W))
) (
   input  logic                                 clk,
   input  logic                                 rst,
   input  logic                                 in_valid,
   input  logic signed [DATA_W-1:0]             in_data,
   input  logic [N_SECT*SLOTS_PER*COEF_W-1:0]   coef_in,
   output logic                                 out_valid,
   output logic signed [DATA_W-1:0]             out_data
);
   localparam int GRP_W  = SLOTS_PER * COEF_W;
   localparam int BANK_W = N_SECT * GRP_W;

   generate
      if (N_SECT < 1)           begin : g_bad_sect  $error("sos_iir_chain: need at least one section"); end
      if (FRAC_W >= COEF_W)     begin : g_bad_frac  $error("sos_iir_chain: fraction wider than coefficient"); end
      if (BANK_W > MAX_BANK)    begin : g_bad_bank  $error("sos_iir_chain: coefficient bank too wide"); end
   endgenerate

   logic [BANK_W-1:0] coef_w;

   coef_bank #(.BANK_W(BANK_W), .USE_PORT_COEF(USE_PORT_COEF), .COEF_INIT(COEF_INIT)) u_bank (
      .coef_port (coef_in),
      .coef_out  (coef_w)
   );

   logic                     link_v [N_SECT+1];
   logic signed [DATA_W-1:0] link_d [N_SECT+1];

   assign link_v[0] = in_valid;
   assign link_d[0] = in_data;

   generate
      for (genvar k = 0; k < N_SECT; k++) begin : g_sect
         sos_stage #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_stage (
            .clk   (clk),
            .rst   (rst),
            .v_in  (link_v[k]),
            .x_in  (link_d[k]),
            .coef  (coef_w[k*GRP_W +: GRP_W]),
            .v_out (link_v[k+1]),
            .y_out (link_d[k+1])
         );
      end
   endgenerate

   assign out_valid = link_v[N_SECT];
   assign out_data  = link_d[N_SECT];

   // R9: the clock after reset leaves the output cleared
   assert_reset_clear_R9: assert property (@(posedge clk)
      rst |=> (!out_valid && out_data == '0));

   // R8: output value changes only together with a valid pulse
   assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> $stable(out_data) || $past(rst));
endmodule

// File: tb/sim_sos_iir_chain.sv
`timescale 1ns/1ps
module sim_sos_iir_chain;
   localparam int NS = 3;
   localparam int DW = 16;
   localparam int CW = 16;

   logic                     clk = 1'b0;
   logic                     rst = 1'b1;
   logic                     in_valid = 1'b0;
   logic signed [DW-1:0]     in_data = '0;
   logic [NS*5*CW-1:0]       coef_in = '0;
   logic                     out_valid;
   logic signed [DW-1:0]     out_data;

   int errors = 0;
   int checks = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   sos_iir_chain #(.N_SECT(NS), .DATA_W(DW), .COEF_W(CW), .FRAC_W(14), .USE_PORT_COEF(1'b1)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .coef_in(coef_in), .out_valid(out_valid), .out_data(out_data)
   );

   // Reference model state, computed from the requirement equations
   longint mb0[NS], mb1[NS], mb2[NS], ma1[NS], ma2[NS];
   longint ms1[NS], ms2[NS];

   function automatic longint rnd_sat(input longint acc);
      longint r;
      r = (acc + 8192) >>> 14;
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
      return r;
   endfunction

   function automatic longint model_step(input longint x);
      longint v, s;
      v = x;
      for (int k = 0; k < NS; k++) begin
         s = rnd_sat((v <<< 14) + ma1[k] * ms1[k] + ma2[k] * ms2[k]);
         v = rnd_sat(mb0[k] * s + mb1[k] * ms1[k] + mb2[k] * ms2[k]);
         ms2[k] = ms1[k];
         ms1[k] = s;
      end
      return v;
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // R4: field j of section k sits at bits [(5k+j)*16 +: 16], j = b0,b1,b2,a1,a2
   task automatic set_sect(input int k, input int b0, input int b1, input int b2, input int a1, input int a2);
      coef_in[(k*5+0)*CW +: CW] = CW'(b0);
      coef_in[(k*5+1)*CW +: CW] = CW'(b1);
      coef_in[(k*5+2)*CW +: CW] = CW'(b2);
      coef_in[(k*5+3)*CW +: CW] = CW'(a1);
      coef_in[(k*5+4)*CW +: CW] = CW'(a2);
      mb0[k] = b0; mb1[k] = b1; mb2[k] = b2; ma1[k] = a1; ma2[k] = a2;
   endtask

   task automatic all_unity();
      for (int k = 0; k < NS; k++) set_sect(k, 16384, 0, 0, 0, 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      for (int k = 0; k < NS; k++) begin ms1[k] = 0; ms2[k] = 0; end
   endtask

   // Push one sample and pin the valid pulse to the third clock (R8)
   task automatic push_one(input string req, input int x);
      longint exp;
      exp = model_step(x);
      @(negedge clk);
      in_valid = 1'b1; in_data = DW'(x);
      @(negedge clk);
      in_valid = 1'b0; in_data = DW'(16'h5A5A);
      check("R8 no early valid", out_valid, 0);
      @(negedge clk);
      check("R8 no early valid", out_valid, 0);
      @(negedge clk);
      check("R8 valid on third clock", out_valid, 1);
      check(req, out_data, exp);
      @(negedge clk);
      check("R8 single pulse", out_valid, 0);
      check("R8 data held", out_data, exp);
   endtask

   // Streamed samples, optionally with idle gaps carrying junk data (R7)
   task automatic run_stream(input string req, input int n, input bit gaps);
      longint exp_q[$];
      int got;
      for (int i = 0; i < n; i++) exp_q.push_back(model_step(((i * 7919 + 13) % 20001) - 10000));
      got = 0;
      fork
         begin
            for (int i = 0; i < n; i++) begin
               @(negedge clk);
               in_valid = 1'b1; in_data = DW'(((i * 7919 + 13) % 20001) - 10000);
               if (gaps) begin
                  @(negedge clk);
                  in_valid = 1'b0; in_data = DW'(i * 12345 + 999);
                  @(negedge clk);
                  in_data = DW'(-i * 3111);
               end
            end
            @(negedge clk);
            in_valid = 1'b0;
         end
         begin
            repeat (n * 3 + NS + 4) begin
               @(negedge clk);
               if (out_valid) begin
                  if (got < n) check(req, out_data, exp_q[got]);
                  got++;
               end
            end
         end
      join
      check("R8 one output per accepted sample", got, n);
   endtask

   task automatic t_reset();
      do_reset();
      check("R9 reset valid", out_valid, 0);
      check("R9 reset data", out_data, 0);
   endtask

   task automatic t_unity();
      do_reset(); all_unity();
      push_one("R3 unity chain", 1234);
      push_one("R3 unity chain", -5000);
      push_one("R3 unity chain", 32767);
   endtask

   task automatic t_delay();
      do_reset();
      for (int k = 0; k < NS; k++) set_sect(k, 0, 16384, 0, 0, 0);
      push_one("R2 delay", 7000);
      check("R2 nothing yet", out_data, 0);
      push_one("R2 delay", 0);
      push_one("R2 delay", 0);
      push_one("R2 delay", 0);
      check("R2 sample arrives after three", out_data, 7000);
   endtask

   task automatic t_feedback();
      do_reset(); all_unity(); set_sect(0, 16384, 0, 0, 8192, 0);
      push_one("R1 positive feedback", 8000);
      push_one("R1 positive feedback", 0);
      check("R1 half decay", out_data, 4000);
      push_one("R1 positive feedback", 0);
      check("R1 quarter decay", out_data, 2000);
      do_reset(); set_sect(0, 16384, 0, 0, -8192, 0);
      push_one("R1 negative feedback", 8000);
      push_one("R1 negative feedback", 0);
      check("R1 sign flip", out_data, -4000);
      do_reset(); set_sect(0, 16384, 0, 0, 0, -8192);
      push_one("R1 second tap", 6000);
      push_one("R1 second tap", 0);
      push_one("R1 second tap", 0);
      check("R1 second tap value", out_data, -3000);
   endtask

   task automatic t_round();
      do_reset(); all_unity(); set_sect(0, 8192, 0, 0, 0, 0);
      push_one("R5 round half up", 3);
      check("R5 plus half", out_data, 2);
      push_one("R5 round half up", -3);
      check("R5 minus half", out_data, -1);
      push_one("R5 round half up", 1);
      check("R5 one half", out_data, 1);
   endtask

   task automatic t_sat();
      do_reset(); all_unity(); set_sect(0, 32767, 0, 0, 0, 0);
      push_one("R6 clamp high", 30000);
      check("R6 clamp high value", out_data, 32767);
      push_one("R6 clamp low", -30000);
      check("R6 clamp low value", out_data, -32768);
      do_reset(); all_unity(); set_sect(0, 16384, 0, 0, 16384, 0);
      push_one("R6 state clamp", 20000);
      push_one("R6 state clamp", 20000);
      check("R6 state clamped", out_data, 32767);
      push_one("R6 state clamp", 0);
      check("R6 clamped state reused", out_data, 32767);
   endtask

   task automatic mixed_coefs();
      set_sect(0, 6000, 9000, 3000, 12000, -6000);
      set_sect(1, 12000, -4000, 2500, -5000, -3000);
      set_sect(2, 9000, 2000, -1500, 3000, 2000);
   endtask

   task automatic t_mixed();
      do_reset(); mixed_coefs();
      run_stream("R4 per-section coefficients", 24, 1'b0);
   endtask

   task automatic t_gaps();
      do_reset(); mixed_coefs();
      run_stream("R7 gaps with junk ignored", 16, 1'b1);
   endtask

   task automatic t_reset_mid();
      do_reset(); all_unity(); set_sect(0, 16384, 0, 0, 15000, 0);
      push_one("R9 build state", 9000);
      push_one("R9 build state", 9000);
      do_reset();
      check("R9 mid reset data", out_data, 0);
      push_one("R9 fresh after reset", 100);
      check("R9 fresh value", out_data, 100);
   endtask

   initial begin
      all_unity();
      t_reset();
      t_unity();
      t_delay();
      t_feedback();
      t_round();
      t_sat();
      t_mixed();
      t_gaps();
      t_reset_mid();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 100000) begin
         errors++;
         checks++;
         $display("FAIL R8 watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule